// File: doc/BRIEF.md
# Segment display command decoder and image memory

This block sits behind a serial-bus slave front end that has already framed the traffic into bytes. It receives a start-of-message strobe, a byte-valid strobe with the byte, and a stop strobe. Each message begins with one or more command bytes. Bit 7 of every command byte says whether another command follows. The first command byte with bit 7 clear is the last command, and every later byte up to the stop is display data. Commands set the drive mode, display enable and bias choice, the data pointer, the cascade subaddress counter, the bank choice and the blink setting.

Display data goes into a memory of 40 columns by 4 rows. There is one column per segment output and one row per backplane. Each data byte is placed at the data pointer. How its eight bits spread over rows and columns depends on the multiplex mode. The pointer then moves past the columns it filled. When it passes the last column it returns to 0 and the subaddress counter steps, so one byte stream can fill a chain of devices. A device only stores bytes while its hardware subaddress matches the counter. A combinational read port returns one column as the waveform generator would use it, with the bank choice and the display enable applied.

Top module: `lcd_cmd_ram`

## Requirements
- R1: After reset: drive mode is 1:4 (code 00), display disabled, bias bit 0, both banks 0, blink frequency 0, alternate blink 0, data pointer 0, subaddress counter 0, and the read port returns 0.
- R2: A command byte with bit 7 set is followed by another command. A command byte with bit 7 clear makes every following byte data, until stop. Bytes after a stop are ignored until the next start of message. A start of message always returns parsing to commands, even in the middle of a data run.
- R3: A command whose bits 6:5 are 10 is a mode-set. Bit 3 is the display enable, bit 2 is the bias bit, and bits 1:0 are the mode: 01 static, 10 1:2, 11 1:3, 00 1:4.
- R4: A command with bit 6 clear loads bits 5:0 into the data pointer. A value above 39 loads 0.
- R5: A command whose bits 6:3 are 1100 loads bits 2:0 into the subaddress counter. A data byte is stored only while the hardware subaddress equals the counter, but the pointer advances either way.
- R6: In static mode a byte fills one row of 8 columns, starting at the pointer. Bit 7 goes to the pointer column and bit 0 to pointer+7.
- R7: In 1:2 mode a byte fills 4 columns, two rows each. Bits 7 and 6 go to the lower and upper row of the pointer column, and so on.
- R8: In 1:3 mode a byte fills rows 0..2 of two columns, then rows 0 and 1 of a third column, taking bits from 7 down to 0. Row 2 of the third column is left unchanged, and the pointer advances by 3.
- R9: In 1:4 mode a byte fills rows 0..3 of 2 columns. Bits 7..4 go to the pointer column, rows 0..3.
- R10: After a data byte the pointer advances by 8, 4, 3 or 2 columns (static, 1:2, 1:3, 1:4). If the result reaches 40, the pointer becomes 0 and the subaddress counter increments modulo 8. Columns past 39 are never written.
- R11: A command whose bits 6:2 are 11110 is a bank-select. Bit 1 is the input bank and bit 0 the output bank. In static and 1:2 modes, input bank 1 writes rows 2/3 instead of 0/1. Output bank 1 makes the read port return rows 2/3 in bits 1:0. In these modes read bits 3:2 are always 0.
- R12: In 1:3 and 1:4 modes the bank setting has no effect: writes start at row 0 and reads return the full column.
- R13: A command whose bits 6:3 are 1110 is a blink-select. Bit 2 is the alternate blink mode and bits 1:0 the blink frequency.
- R14: While the display is disabled the read port returns 0. The memory contents are kept, and they reappear when the display is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| som_i | input | 1 | Start-of-message strobe |
| byte_vld_i | input | 1 | Byte strobe |
| byte_i | input | 8 | Received byte |
| stop_i | input | 1 | Stop strobe |
| hw_subaddr_i | input | 3 | Hardware subaddress of this device |
| rd_col_i | input | 6 | Column to read |
| rd_bits_o | output | 4 | Column as seen by the drivers, bit n = row n |
| mux_mode_o | output | 2 | Drive mode code |
| disp_en_o | output | 1 | Display enable |
| bias_o | output | 1 | Bias selection bit |
| blink_freq_o | output | 2 | Blink frequency code |
| blink_alt_o | output | 1 | Alternate blink mode |
| data_ptr_o | output | 6 | Data pointer |
| sub_cnt_o | output | 3 | Subaddress counter |

## Verification
Data bytes are written in each of the four drive modes, using bit patterns that are asymmetric within a column. Such a pattern shows a row order swapped or a column skipped. In 1:3 mode the partial third column is included, where row 2 must stay untouched. The bank bits are set both in static mode, where write and read rows move, and in 1:3 and 1:4 modes, where the same settings must change nothing. Pointer runs that reach column 39 check the wrap and the subaddress step, and a byte sent while the counter mismatches must leave memory unchanged. Command chains with and without the continuation bit, a start of message in the middle of data, and bytes after a stop show whether the parser takes each byte as a command, as data, or ignores it.

// File: rtl/lcd_cmd_pkg.sv
package lcd_cmd_pkg;
  localparam int PTR_W = 6;
  localparam int SUB_W = 3;
  localparam int ROWS  = 4;

  typedef enum logic [1:0] {
    MUX4 = 2'b00,
    MUX1 = 2'b01,
    MUX2 = 2'b10,
    MUX3 = 2'b11
  } mux_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_CMD  = 2'b01,
    PH_DATA = 2'b10
  } phase_e;

  typedef struct packed {
    logic [ROWS-1:0] mask;
    logic [ROWS-1:0] val;
  } fill_t;

  function automatic int rows_of(mux_e m);
    case (m)
      MUX1:    return 1;
      MUX2:    return 2;
      MUX3:    return 3;
      default: return 4;
    endcase
  endfunction

  // columns touched by one byte = pointer step
  function automatic logic [3:0] step_of(mux_e m);
    case (m)
      MUX1:    return 4'd8;
      MUX2:    return 4'd4;
      MUX3:    return 4'd3;
      default: return 4'd2;
    endcase
  endfunction

  function automatic logic paired(mux_e m);
    return (m == MUX1) || (m == MUX2);
  endfunction

  // bits of byte b landing in the k-th column of the group
  function automatic fill_t col_fill(mux_e m, logic bank, logic [2:0] k, logic [7:0] b);
    fill_t f;
    int n, rb, idx;
    f  = '0;
    n  = rows_of(m);
    rb = (bank && paired(m)) ? 2 : 0;
    for (int i = 0; i < ROWS; i++) begin
      if (i < n) begin
        idx = int'(k) * n + i;
        if (idx < 8) begin
          f.mask[rb+i] = 1'b1;
          f.val[rb+i]  = b[7-idx];
        end
      end
    end
    return f;
  endfunction
endpackage

// File: rtl/lcd_cmd_decode.sv
module lcd_cmd_decode
  import lcd_cmd_pkg::*;
#(
  parameter int NUM_COLS = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             som_i,
  input  logic             byte_vld_i,
  input  logic [7:0]       byte_i,
  input  logic             stop_i,
  input  logic [SUB_W-1:0] hw_subaddr_i,
  output mux_e             mux_o,
  output logic             disp_en_o,
  output logic             bias_o,
  output logic             in_bank_o,
  output logic             out_bank_o,
  output logic [1:0]       blink_freq_o,
  output logic             blink_alt_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic [SUB_W-1:0] sub_cnt_o,
  output logic             data_phase_o,
  output logic             wr_en_o
);
  localparam logic [PTR_W:0]   LIMIT = (PTR_W+1)'(NUM_COLS);
  localparam logic [PTR_W-1:0] LAST  = PTR_W'(NUM_COLS - 1);

  phase_e           phase_q, phase_d, phase_eff;
  mux_e             mux_q;
  logic             en_q, bias_q, ibank_q, obank_q, alt_q;
  logic [1:0]       freq_q;
  logic [PTR_W-1:0] ptr_q;
  logic [SUB_W-1:0] sub_q;
  logic             take, is_cmd, is_data;
  logic [PTR_W:0]   ptr_sum;

  assign phase_eff = som_i ? PH_CMD : phase_q;
  assign take      = byte_vld_i && (phase_eff != PH_IDLE);
  assign is_cmd    = take && (phase_eff == PH_CMD);
  assign is_data   = take && (phase_eff == PH_DATA);
  assign ptr_sum   = {1'b0, ptr_q} + {{(PTR_W-3){1'b0}}, step_of(mux_q)};

  always_comb begin
    phase_d = phase_eff;
    if (is_cmd && !byte_i[7]) phase_d = PH_DATA;
    if (stop_i)               phase_d = PH_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      mux_q   <= MUX4;
      en_q    <= 1'b0;
      bias_q  <= 1'b0;
      ibank_q <= 1'b0;
      obank_q <= 1'b0;
      alt_q   <= 1'b0;
      freq_q  <= 2'b00;
      ptr_q   <= '0;
      sub_q   <= '0;
    end else begin
      phase_q <= phase_d;
      if (is_cmd) begin
        casez (byte_i[6:0])
          7'b0??????: ptr_q <= (byte_i[5:0] > LAST) ? '0 : byte_i[PTR_W-1:0];
          7'b10?????: begin
            en_q   <= byte_i[3];
            bias_q <= byte_i[2];
            mux_q  <= mux_e'(byte_i[1:0]);
          end
          7'b1100???: sub_q <= byte_i[SUB_W-1:0];
          7'b11110??: begin
            ibank_q <= byte_i[1];
            obank_q <= byte_i[0];
          end
          7'b1110???: begin
            alt_q  <= byte_i[2];
            freq_q <= byte_i[1:0];
          end
          default: ;
        endcase
      end else if (is_data) begin
        if (ptr_sum >= LIMIT) begin
          ptr_q <= '0;
          sub_q <= sub_q + 1'b1;
        end else begin
          ptr_q <= ptr_sum[PTR_W-1:0];
        end
      end
    end
  end

  assign mux_o        = mux_q;
  assign disp_en_o    = en_q;
  assign bias_o       = bias_q;
  assign in_bank_o    = ibank_q;
  assign out_bank_o   = obank_q;
  assign blink_freq_o = freq_q;
  assign blink_alt_o  = alt_q;
  assign ptr_o        = ptr_q;
  assign sub_cnt_o    = sub_q;
  assign data_phase_o = (phase_q == PH_DATA);
  assign wr_en_o      = is_data && (hw_subaddr_i == sub_q);
endmodule

// File: rtl/lcd_disp_ram.sv
module lcd_disp_ram
  import lcd_cmd_pkg::*;
#(
  parameter int NUM_COLS = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_byte_i,
  input  logic [PTR_W-1:0] wr_ptr_i,
  input  mux_e             mux_i,
  input  logic             in_bank_i,
  input  logic             out_bank_i,
  input  logic             disp_en_i,
  input  logic [PTR_W-1:0] rd_col_i,
  output logic [ROWS-1:0]  rd_bits_o
);
  logic [ROWS-1:0] mem_q [NUM_COLS];
  logic [ROWS-1:0] raw;

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    fill_t f;
    logic  hit;
    int    off;

    always_comb begin
      off = c - int'(wr_ptr_i);
      hit = wr_en_i && (off >= 0) && (off < int'(step_of(mux_i)));
      f   = col_fill(mux_i, in_bank_i, off[2:0], wr_byte_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  mem_q[c] <= '0;
      else if (hit) mem_q[c] <= (mem_q[c] & ~f.mask) | (f.val & f.mask);
    end
  end

  always_comb begin
    raw = '0;
    for (int c = 0; c < NUM_COLS; c++)
      if (rd_col_i == PTR_W'(c)) raw = mem_q[c];
  end

  always_comb begin
    if (!disp_en_i)       rd_bits_o = '0;
    else if (paired(mux_i)) rd_bits_o = {2'b00, out_bank_i ? raw[3:2] : raw[1:0]};
    else                  rd_bits_o = raw;
  end
endmodule

// File: rtl/lcd_cmd_ram.sv
module lcd_cmd_ram
  import lcd_cmd_pkg::*;
#(
  parameter int NUM_COLS = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             som_i,
  input  logic             byte_vld_i,
  input  logic [7:0]       byte_i,
  input  logic             stop_i,
  input  logic [SUB_W-1:0] hw_subaddr_i,
  input  logic [PTR_W-1:0] rd_col_i,
  output logic [ROWS-1:0]  rd_bits_o,
  output logic [1:0]       mux_mode_o,
  output logic             disp_en_o,
  output logic             bias_o,
  output logic [1:0]       blink_freq_o,
  output logic             blink_alt_o,
  output logic [PTR_W-1:0] data_ptr_o,
  output logic [SUB_W-1:0] sub_cnt_o
);
  mux_e mux;
  logic in_bank, out_bank, data_phase, wr_en;

  lcd_cmd_decode #(.NUM_COLS(NUM_COLS)) u_dec (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .som_i        (som_i),
    .byte_vld_i   (byte_vld_i),
    .byte_i       (byte_i),
    .stop_i       (stop_i),
    .hw_subaddr_i (hw_subaddr_i),
    .mux_o        (mux),
    .disp_en_o    (disp_en_o),
    .bias_o       (bias_o),
    .in_bank_o    (in_bank),
    .out_bank_o   (out_bank),
    .blink_freq_o (blink_freq_o),
    .blink_alt_o  (blink_alt_o),
    .ptr_o        (data_ptr_o),
    .sub_cnt_o    (sub_cnt_o),
    .data_phase_o (data_phase),
    .wr_en_o      (wr_en)
  );

  lcd_disp_ram #(.NUM_COLS(NUM_COLS)) u_ram (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_byte_i  (byte_i),
    .wr_ptr_i   (data_ptr_o),
    .mux_i      (mux),
    .in_bank_i  (in_bank),
    .out_bank_i (out_bank),
    .disp_en_i  (disp_en_o),
    .rd_col_i   (rd_col_i),
    .rd_bits_o  (rd_bits_o)
  );

  assign mux_mode_o = mux;
endmodule

// File: rtl/lcd_cmd_ram_chk.sv
module lcd_cmd_ram_chk #(
  parameter int NUM_COLS = 40
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       som_i,
  input logic       byte_vld_i,
  input logic       stop_i,
  input logic       data_phase,
  input logic [1:0] mux_mode_o,
  input logic       disp_en_o,
  input logic [3:0] rd_bits_o,
  input logic [5:0] data_ptr_o,
  input logic [2:0] sub_cnt_o
);
  assert_ptr_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(data_ptr_o) < NUM_COLS);

  assert_dark_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !disp_en_o |-> rd_bits_o == 4'b0000);

  assert_cfg_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_phase && byte_vld_i && !som_i) |=> ($stable(mux_mode_o) && $stable(disp_en_o)));

  assert_stop_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !data_phase);

  assert_wrap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_phase && byte_vld_i && !som_i) |=> ($stable(sub_cnt_o) || data_ptr_o == 6'd0));

  assert_pair_rows_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mux_mode_o == 2'b01 || mux_mode_o == 2'b10) |-> rd_bits_o[3:2] == 2'b00);
endmodule

bind lcd_cmd_ram lcd_cmd_ram_chk #(.NUM_COLS(NUM_COLS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .som_i      (som_i),
  .byte_vld_i (byte_vld_i),
  .stop_i     (stop_i),
  .data_phase (data_phase),
  .mux_mode_o (mux_mode_o),
  .disp_en_o  (disp_en_o),
  .rd_bits_o  (rd_bits_o),
  .data_ptr_o (data_ptr_o),
  .sub_cnt_o  (sub_cnt_o)
);

// File: tb/lcd_cmd_ram_tb_top.sv
`timescale 1ns/1ps
module lcd_cmd_ram_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       som = 1'b0, vld = 1'b0, stop = 1'b0;
  logic [7:0] bt = 8'h00;
  logic [2:0] hw_sub = 3'd0;
  logic [5:0] rd_col = 6'd0;
  logic [3:0] rd_bits;
  logic [1:0] mux_mode, blink_freq;
  logic       disp_en, bias, blink_alt;
  logic [5:0] ptr;
  logic [2:0] sub_cnt;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  lcd_cmd_ram dut_i (
    .clk_i(clk), .rst_ni(rst_n), .som_i(som), .byte_vld_i(vld), .byte_i(bt),
    .stop_i(stop), .hw_subaddr_i(hw_sub), .rd_col_i(rd_col), .rd_bits_o(rd_bits),
    .mux_mode_o(mux_mode), .disp_en_o(disp_en), .bias_o(bias),
    .blink_freq_o(blink_freq), .blink_alt_o(blink_alt),
    .data_ptr_o(ptr), .sub_cnt_o(sub_cnt)
  );

  task automatic chk(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic col_is(string tag, int col, int exp);
    rd_col = 6'(col);
    #1;
    chk(tag, int'(rd_bits), exp);
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk); vld = 1'b1; bt = b;
    @(negedge clk); vld = 1'b0;
  endtask

  task automatic start_msg();
    @(negedge clk); som = 1'b1;
    @(negedge clk); som = 1'b0;
  endtask

  task automatic end_msg();
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 mode", mux_mode, 0);
    chk("R1 enable", disp_en, 0);
    chk("R1 bias", bias, 0);
    chk("R1 blink freq", blink_freq, 0);
    chk("R1 blink alt", blink_alt, 0);
    chk("R1 pointer", ptr, 0);
    chk("R1 subaddr", sub_cnt, 0);
    col_is("R1 read", 0, 0);
  endtask

  task automatic t_static();
    start_msg(); send(8'hC9); send(8'h00);
    chk("R3 mode static", mux_mode, 1);
    chk("R3 enable", disp_en, 1);
    send(8'hA5);
    col_is("R6 col0", 0, 1); col_is("R6 col1", 1, 0);
    col_is("R6 col2", 2, 1); col_is("R6 col7", 7, 1);
    chk("R10 step static", ptr, 8);
    end_msg();
  endtask

  task automatic t_bank_static();
    start_msg(); send(8'hFA); send(8'h08); send(8'hFF);
    col_is("R11 in bank hidden", 8, 0);
    start_msg(); send(8'h79);
    col_is("R11 out bank col8", 8, 1);
    col_is("R11 out bank col0", 0, 0);
  endtask

  task automatic t_after_stop();
    end_msg(); send(8'hFF);
    chk("R2 ignored after stop", ptr, 16);
  endtask

  task automatic t_mux2();
    start_msg(); send(8'hCA); send(8'hF8); send(8'h14);
    col_is("R2 col16 untouched", 16, 0);
    send(8'hB4);
    col_is("R7 col20", 20, 1); col_is("R7 col21", 21, 3);
    col_is("R7 col22", 22, 2); col_is("R7 col23", 23, 0);
    chk("R10 step 1:2", ptr, 24);
    end_msg();
  endtask

  task automatic t_mux3();
    start_msg(); send(8'hCB); send(8'hFB); send(8'h1E); send(8'hE5);
    col_is("R8 col30", 30, 7); col_is("R8 col31", 31, 4);
    col_is("R8 col32 partial", 32, 2);
    col_is("R12 bank ignored col8", 8, 4);
    chk("R10 step 1:3", ptr, 33);
    end_msg();
  endtask

  task automatic t_mux4();
    start_msg(); send(8'hC8); send(8'h24); send(8'h9C);
    col_is("R9 col36", 36, 9); col_is("R9 col37", 37, 3);
    col_is("R12 full column", 0, 1);
    send(8'h3C);
    col_is("R9 col38", 38, 12); col_is("R9 col39", 39, 3);
    chk("R10 wrap ptr", ptr, 0);
    chk("R10 wrap subaddr", sub_cnt, 1);
    send(8'hFF);
    col_is("R5 mismatch col0", 0, 1); col_is("R5 mismatch col1", 1, 0);
    chk("R5 ptr advances", ptr, 2);
    end_msg();
  endtask

  task automatic t_devsel();
    start_msg(); send(8'h60);
    chk("R5 subaddr load", sub_cnt, 0);
    send(8'hF0);
    col_is("R5 match col2", 2, 15); col_is("R5 match col3", 3, 0);
    end_msg();
  endtask

  task automatic t_clamp();
    start_msg(); send(8'hA7);
    chk("R4 load 39", ptr, 39);
    send(8'h28);
    chk("R4 clamp", ptr, 0);
    end_msg();
  endtask

  task automatic t_continuation();
    start_msg(); send(8'h85); send(8'h0A);
    chk("R2 second command", ptr, 10);
    send(8'h00);
    chk("R2 data after last", ptr, 12);
    start_msg(); send(8'h86);
    chk("R2 restart to command", ptr, 6);
    end_msg();
  endtask

  task automatic t_blink();
    start_msg(); send(8'h76);
    chk("R13 alt", blink_alt, 1);
    chk("R13 freq", blink_freq, 2);
    end_msg();
  endtask

  task automatic t_disable();
    start_msg(); send(8'h40);
    chk("R14 disabled", disp_en, 0);
    col_is("R14 dark", 2, 0);
    start_msg(); send(8'h4C);
    chk("R3 bias", bias, 1);
    col_is("R14 restored", 2, 15);
    end_msg();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_static();
    t_bank_static();
    t_after_stop();
    t_mux2();
    t_mux3();
    t_mux4();
    t_devsel();
    t_clamp();
    t_continuation();
    t_blink();
    t_disable();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule